// File: doc/BRIEF.md
# Sparse-addressed microcode sequencer

This block produces the control-store address for a microcoded 16-bit processor and holds the control store itself. It has no jump table and no next-address field. The address is a concatenation of three fields. The top field is four opcode bits of the fetched instruction, copied without decoding. The middle field is a routine class chosen by the instruction decoder; it is held for the whole instruction. The bottom field is a step counter that restarts at zero for each instruction. Most of the 4096 locations stay empty. That spare room lets each routine start on a 16-word boundary, and only the step counter ever counts.

A 32-bit control word is read at every address. Its four low bits steer the sequencer:
- bit 0 marks the fetch step;
- bit 1 asks for the branch outcome;
- bit 2 ends the routine when the zero input is high;
- bit 3 ends the routine when the zero input is low.

All the other bits go to the datapath unchanged. Every conditional branch shares one routine. The condition is evaluated outside the block and replaces the top bit of the step field, so the taken path runs in steps 8 to 15 and the not-taken path stays in steps 0 to 7. All register-to-register ALU operations also share one routine, and the operation code reaches the ALU through a separate output. The control store is loaded through a write port, normally while reset is held. Location 0 holds the fetch routine.

Top module: `useq_top`

## Requirements
- R1: On a clock edge where control bit 0 (fetch) is set, the next address is {instr_i[15:12], cls_i, 4'h0}. On the same edge the instruction register loads instr_i.
- R2: While rst is high on a clock edge, the address becomes 0, err_o clears, ir_o and alu_op_o clear, and cw_o takes the word stored at address 0.
- R3: If no fetch, end or branch applies and the step field is below 15, the address goes up by exactly 1. Address bits [11:4] do not change.
- R4: On an edge where control bit 1 (branch) is set at step s < 15, the next step is {cond_i, low three bits of s+1}. Bits [11:4] are kept, so the taken path continues in steps 8..15 and the not-taken path in steps 0..7.
- R5: When control bit 2 is set and zero_i is 1, or control bit 3 is set and zero_i is 0, the next address is 0. If the selected condition does not hold, the end bit has no effect and stepping continues.
- R6: Fetch takes priority over end, and end takes priority over branch and stepping.
- R7: If the step field is 15 and a plain step or a branch is due, the address holds and err_o sets. err_o stays set until reset.
- R8: cw_o is the control word stored at the address shown on addr_o. Locations never written read as 0. A word written through wr_en_i, wr_addr_i and wr_data_i is read for any address reached in a later cycle.
- R9: ir_o shows the instruction held since the last fetch, and alu_op_o shows its bits [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 16 | Fetched instruction word |
| cls_i | input | 4 | Routine class from the instruction decoder |
| cond_i | input | 1 | Evaluated branch condition |
| zero_i | input | 1 | Zero indication used by the end bits |
| wr_en_i | input | 1 | Control-store write enable |
| wr_addr_i | input | 12 | Control-store write address |
| wr_data_i | input | 32 | Control-store write data |
| addr_o | output | 12 | Current control-store address |
| cw_o | output | 32 | Control word at addr_o |
| ir_o | output | 16 | Instruction register |
| alu_op_o | output | 4 | ALU operation code from the instruction register |
| err_o | output | 1 | Sticky step-overflow flag |

## Verification
The assertions assume that cw_o shows the word stored at addr_o. That only holds if the store is not written at the address being read in the same cycle, so the stimulus loads the store only while reset is held, and keeps reset high for two cycles after the last write. The assertions also assume that instr_i, cls_i, cond_i and zero_i are stable around each edge. The stimulus changes them only on the falling edge. Every control word the stimulus uses is either zero or a combination of the four sequencing bits plus a tag in the upper bits, so each dispatch, branch, end and overflow path has an address sequence the bench can predict.

// File: rtl/useq_pkg.sv
package useq_pkg;
  // sequencing bits inside the control word
  localparam int CW_FETCH  = 0;
  localparam int CW_BRANCH = 1;
  localparam int CW_END_Z  = 2;
  localparam int CW_END_NZ = 3;

  typedef enum logic [2:0] {
    ACT_FETCH,
    ACT_END,
    ACT_SAT,
    ACT_BRANCH,
    ACT_STEP
  } seq_act_e;
endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // empty locations must read as zero
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  // single write port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int OPC_W  = 4,
  parameter int CLS_W  = 4,
  parameter int STEP_W = 4
) (
  input  logic              fetch,
  input  logic              branch,
  input  logic              end_z,
  input  logic              end_nz,
  input  logic              zero,
  input  logic              cond,
  input  logic [OPC_W-1:0]  opc_in,
  input  logic [CLS_W-1:0]  cls_in,
  input  logic [OPC_W-1:0]  opc_q,
  input  logic [CLS_W-1:0]  cls_q,
  input  logic [STEP_W-1:0] step_q,
  output logic [OPC_W-1:0]  opc_d,
  output logic [CLS_W-1:0]  cls_d,
  output logic [STEP_W-1:0] step_d,
  output seq_act_e          act
);
  localparam logic [STEP_W-1:0] STEP_LAST = {STEP_W{1'b1}};

  logic              finish;
  logic [STEP_W-1:0] step_inc;

  assign finish   = (end_z & zero) | (end_nz & ~zero);
  assign step_inc = step_q + STEP_W'(1);

  always_comb begin
    opc_d  = opc_q;
    cls_d  = cls_q;
    step_d = step_q;
    act    = ACT_STEP;
    if (fetch) begin
      opc_d  = opc_in;
      cls_d  = cls_in;
      step_d = '0;
      act    = ACT_FETCH;
    end else if (finish) begin
      opc_d  = '0;
      cls_d  = '0;
      step_d = '0;
      act    = ACT_END;
    end else if (step_q == STEP_LAST) begin
      act    = ACT_SAT;
    end else if (branch) begin
      step_d = {cond, step_inc[STEP_W-2:0]};
      act    = ACT_BRANCH;
    end else begin
      step_d = step_inc;
    end
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int OPC_W   = 4,
  parameter int OPC_LSB = 12,
  parameter int CLS_W   = 4,
  parameter int STEP_W  = 4,
  parameter int CW_W    = 32,
  parameter int ALU_W   = 4,
  localparam int ADDR_W = OPC_W + CLS_W + STEP_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [CLS_W-1:0]   cls_i,
  input  logic               cond_i,
  input  logic               zero_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [CW_W-1:0]    wr_data_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [CW_W-1:0]    cw_o,
  output logic [INSTR_W-1:0] ir_o,
  output logic [ALU_W-1:0]   alu_op_o,
  output logic               err_o
);
  logic [OPC_W-1:0]  opc_q, opc_d;
  logic [CLS_W-1:0]  cls_q, cls_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [INSTR_W-1:0] ir_q;
  logic              err_q;
  logic [CW_W-1:0]   cw_q;
  logic [ADDR_W-1:0] rd_addr;
  seq_act_e          act;

  useq_next #(
    .OPC_W (OPC_W),
    .CLS_W (CLS_W),
    .STEP_W(STEP_W)
  ) u_next (
    .fetch (cw_q[CW_FETCH]),
    .branch(cw_q[CW_BRANCH]),
    .end_z (cw_q[CW_END_Z]),
    .end_nz(cw_q[CW_END_NZ]),
    .zero  (zero_i),
    .cond  (cond_i),
    .opc_in(instr_i[OPC_LSB +: OPC_W]),
    .cls_in(cls_i),
    .opc_q (opc_q),
    .cls_q (cls_q),
    .step_q(step_q),
    .opc_d (opc_d),
    .cls_d (cls_d),
    .step_d(step_d),
    .act   (act)
  );

  // the store is read at the address about to be registered, so cw_q
  // always belongs to the address held in opc_q/cls_q/step_q
  assign rd_addr = rst ? '0 : {opc_d, cls_d, step_d};

  useq_store #(
    .ADDR_W(ADDR_W),
    .DATA_W(CW_W)
  ) u_store (
    .clk  (clk),
    .we   (wr_en_i),
    .waddr(wr_addr_i),
    .wdata(wr_data_i),
    .raddr(rd_addr),
    .rdata(cw_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      opc_q  <= '0;
      cls_q  <= '0;
      step_q <= '0;
      ir_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      opc_q  <= opc_d;
      cls_q  <= cls_d;
      step_q <= step_d;
      if (act == ACT_FETCH) ir_q <= instr_i;
      if (act == ACT_SAT) err_q <= 1'b1;
    end
  end

  assign addr_o   = {opc_q, cls_q, step_q};
  assign cw_o     = cw_q;
  assign ir_o     = ir_q;
  assign alu_op_o = ir_q[ALU_W-1:0];
  assign err_o    = err_q;
endmodule

// File: rtl/useq_checker.sv
module useq_checker
  import useq_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int OPC_W   = 4,
  parameter int OPC_LSB = 12,
  parameter int CLS_W   = 4,
  parameter int STEP_W  = 4,
  parameter int CW_W    = 32,
  localparam int ADDR_W = OPC_W + CLS_W + STEP_W
) (
  input logic               clk,
  input logic               rst,
  input logic [INSTR_W-1:0] instr,
  input logic [CLS_W-1:0]   cls,
  input logic               cond,
  input logic               zero,
  input logic [ADDR_W-1:0]  addr,
  input logic [CW_W-1:0]    cw,
  input logic               err
);
  logic f_c, b_c, e_c, top_c;
  assign f_c   = cw[CW_FETCH];
  assign b_c   = cw[CW_BRANCH];
  assign e_c   = (cw[CW_END_Z] & zero) | (cw[CW_END_NZ] & ~zero);
  assign top_c = (addr[STEP_W-1:0] == {STEP_W{1'b1}});

  assert_reset_R2: assert property (@(posedge clk)
    rst |=> (addr == '0 && !err));

  assert_dispatch_R1: assert property (@(posedge clk) disable iff (rst)
    f_c |=> addr == {$past(instr[OPC_LSB +: OPC_W]), $past(cls), {STEP_W{1'b0}}});

  assert_end_R5: assert property (@(posedge clk) disable iff (rst)
    (!f_c && e_c) |=> addr == '0);

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!f_c && !e_c && !b_c && !top_c) |=> addr == $past(addr) + ADDR_W'(1));

  assert_branch_R4: assert property (@(posedge clk) disable iff (rst)
    (!f_c && !e_c && b_c && !top_c) |=>
      (addr[STEP_W-1] == $past(cond) &&
       addr[ADDR_W-1:STEP_W] == $past(addr[ADDR_W-1:STEP_W])));

  assert_saturate_R7: assert property (@(posedge clk) disable iff (rst)
    (!f_c && !e_c && top_c) |=> (err && $stable(addr)));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

bind useq_top useq_checker #(
  .INSTR_W(INSTR_W),
  .OPC_W  (OPC_W),
  .OPC_LSB(OPC_LSB),
  .CLS_W  (CLS_W),
  .STEP_W (STEP_W),
  .CW_W   (CW_W)
) u_chk (
  .clk  (clk),
  .rst  (rst),
  .instr(instr_i),
  .cls  (cls_i),
  .cond (cond_i),
  .zero (zero_i),
  .addr (addr_o),
  .cw   (cw_o),
  .err  (err_o)
);

// File: tb/useq_top_test.sv
module useq_top_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] instr;
  logic [3:0]  cls;
  logic        cond, zero;
  logic        wr_en;
  logic [11:0] wr_addr;
  logic [31:0] wr_data;
  logic [11:0] addr;
  logic [31:0] cw;
  logic [15:0] ir;
  logic [3:0]  alu_op;
  logic        err;

  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  useq_top uut (
    .clk(clk), .rst(rst), .instr_i(instr), .cls_i(cls), .cond_i(cond),
    .zero_i(zero), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .addr_o(addr), .cw_o(cw), .ir_o(ir), .alu_op_o(alu_op), .err_o(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  function automatic logic [11:0] ua(input int op, input int c, input int s);
    return {4'(op), 4'(c), 4'(s)};
  endfunction

  function automatic logic [31:0] tag(input int op, input int c);
    return {4'(op), 4'(c), 20'h0, 4'h4};
  endfunction

  function automatic bit reserved(input int op, input int c);
    return (op == 0 && c == 0) || (op == 5 && c == 6) || (op == 7 && c == 1) ||
           (op == 9 && c == 9) || (op == 3 && c == 4) || (op == 11 && c == 2);
  endfunction

  task automatic do_fetch(input int op, input int c, input logic [3:0] lo);
    instr = {4'(op), 8'h5A, lo};
    cls = 4'(c);
    tick();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; instr = '0; cls = '0; cond = 1'b0; zero = 1'b1;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    @(negedge clk);
    // load the control store under reset
    wr(12'h000, 32'h1);
    for (int op = 0; op < 16; op++)
      for (int c = 0; c < 16; c++)
        if (!reserved(op, c)) wr(ua(op, c, 0), tag(op, c));
    wr(ua(5, 6, 1), 32'h4);
    wr(ua(5, 6, 3), 32'h8);
    wr(ua(7, 1, 1), 32'h2);
    wr(ua(7, 1, 2), 32'hC);
    wr(ua(7, 1, 10), 32'hC);
    wr(ua(3, 4, 0), 32'h5);
    wr(ua(11, 2, 7), 32'h2);
    do_reset();

    // R2 reset state
    chk("R2 addr", 32'(addr), 32'h0);
    chk("R2 err", 32'(err), 32'h0);
    chk("R2 cw", cw, 32'h1);
    chk("R2 alu_op", 32'(alu_op), 32'h0);

    // R1/R8/R9/R5 dispatch sweep over every opcode and class
    zero = 1'b1;
    for (int op = 0; op < 16; op++)
      for (int c = 0; c < 16; c++)
        if (!reserved(op, c)) begin
          do_fetch(op, c, 4'(op ^ c));
          chk("R1 dispatch addr", 32'(addr), 32'(ua(op, c, 0)));
          chk("R8 word at dispatch", cw, tag(op, c));
          chk("R9 alu_op", 32'(alu_op), 32'(op ^ c));
          chk("R9 ir", 32'(ir), 32'({4'(op), 8'h5A, 4'(op ^ c)}));
          tick();
          chk("R5 end to fetch", 32'(addr), 32'h0);
        end

    // R3 stepping, R5 conditional end ignored / taken
    zero = 1'b0;
    do_fetch(5, 6, 4'h0);
    chk("R3 step0", 32'(addr), 32'h560);
    tick();
    chk("R3 step1", 32'(addr), 32'h561);
    chk("R8 step1 word", cw, 32'h4);
    tick();
    chk("R5 end-if-zero ignored", 32'(addr), 32'h562);
    chk("R8 unwritten reads zero", cw, 32'h0);
    tick();
    chk("R3 step3", 32'(addr), 32'h563);
    tick();
    chk("R5 end-if-nonzero", 32'(addr), 32'h0);

    // R4 branch taken and not taken
    zero = 1'b1;
    cond = 1'b1;
    do_fetch(7, 1, 4'h0);
    tick();
    chk("R4 branch step", 32'(addr), 32'h711);
    tick();
    chk("R4 taken path", 32'(addr), 32'h71A);
    tick();
    chk("R5 end after taken", 32'(addr), 32'h0);
    cond = 1'b0;
    do_fetch(7, 1, 4'h0);
    tick();
    tick();
    chk("R4 not-taken path", 32'(addr), 32'h712);
    tick();
    chk("R5 end after not-taken", 32'(addr), 32'h0);

    // R6 fetch beats end
    zero = 1'b1;
    do_fetch(3, 4, 4'h1);
    chk("R6 routine start", 32'(addr), 32'h340);
    instr = {4'hA, 8'h5A, 4'h7};
    cls = 4'hB;
    tick();
    chk("R6 fetch over end", 32'(addr), 32'hAB0);
    chk("R6 word", cw, tag(10, 11));
    chk("R9 alu_op after refetch", 32'(alu_op), 32'h7);
    tick();
    chk("R5 end after refetch", 32'(addr), 32'h0);

    // R4 branch from step 7 not taken wraps to step 0
    cond = 1'b0;
    do_fetch(11, 2, 4'h0);
    for (int i = 0; i < 7; i++) tick();
    chk("R3 reach step7", 32'(addr), 32'hB27);
    tick();
    chk("R4 branch at step7", 32'(addr), 32'hB20);
    do_reset();
    chk("R2 reset mid-routine", 32'(addr), 32'h0);

    // R7 overflow saturation
    do_fetch(9, 9, 4'h0);
    chk("R8 empty routine word", cw, 32'h0);
    for (int i = 0; i < 15; i++) tick();
    chk("R7 at step15", 32'(addr), 32'h99F);
    chk("R7 no err yet", 32'(err), 32'h0);
    tick();
    chk("R7 hold", 32'(addr), 32'h99F);
    chk("R7 err set", 32'(err), 32'h1);
    tick();
    chk("R7 err sticky", 32'(err), 32'h1);
    do_reset();
    chk("R2 err cleared", 32'(err), 32'h0);
    chk("R2 addr after overflow", 32'(addr), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule